// File: doc/BRIEF.md
# DMA Handshake Bus Port

This block is the slave side of a generic DMA bus. It moves 8-bit or 16-bit words between the external bus pins and an internal buffer interface. On the inbound path it pushes one word into the buffer for each capture strobe. On the outbound path it drives a buffer word onto the bus while the drive strobe is held. The port requests service on DREQ when the buffer can take or supply a word. It also flags each end-of-transfer assertion.

Two CPU-written registers shape the pins.

- The polarity register (`reg_sel` = 0) is one byte. Bits 7:6 select the byte order. Bit 5 is the EOT polarity. Bit 4 is reserved and always stored as 0. Bit 3 is the DACK polarity, bit 2 the DREQ polarity, bit 1 the write-strobe polarity and bit 0 the read-strobe polarity.
- The transfer register (`reg_sel` = 1) holds four bits. Bits 1:0 select the strobe mode, bit 2 selects the width (1 = 16 bits) and bit 3 selects the direction (1 = port to bus).

Every handshake input passes through a two-flop synchronizer. It is then normalised to active-high before any decoding. The tri-state bus and the tri-state DREQ pin are represented by separate output-enable signals.

Top module: `dmaport_top`

## Requirements
- R1: After `rst_n` and after a `bus_rst` cycle, the polarity register holds 0x04. This means every input pin is active low and DREQ is active high. `bus_rst` wins over a polarity-register write in the same cycle.
- R2: `dreq_oe` is 0 from reset until the first transfer-register write. It becomes 1 two clock edges after the write cycle and stays 1.
- R3: The logical request is true when the port is configured, the mode is not 11, and the selected buffer flag is high. The selected flag is `buf_rd_avail` when bit 3 = 1 and `buf_wr_ready` otherwise. The request is registered once. `dreq_pin` equals the logical request XNOR polarity bit 2.
- R4: The polarity bits map as follows: bit 5 is EOT, bit 3 is DACK, bit 1 is the write strobe and bit 0 is the read strobe. A bit value of 0 makes that input active low and 1 makes it active high. Bit 4 is stored as 0.
- R5: Inbound (transfer bit 3 = 0), the capture strobe is the write strobe in mode 00 and DACK in modes 01 and 10. Asserting it gives one `buf_wr_valid` pulse with the bus word three edges after the pin change. The other strobes produce no pulse.
- R6: Outbound (transfer bit 3 = 1), the drive strobe is the read strobe in modes 00 and 01 and DACK in mode 10. `bus_doe` rises three edges after the strobe asserts and falls three edges after release. `buf_rd_pop` pulses once in the cycle `bus_doe` falls. The other strobes leave `bus_doe` low.
- R7: With polarity bits 7:6 = 01 and a 16-bit bus, the two byte lanes are exchanged in both directions. Values 00, 10 and 11 keep the normal order, with the high byte on bus bits 15:8.
- R8: With transfer bit 2 = 0 (8-bit bus), only bus bits 7:0 carry data. The upper byte of `buf_wr_data` and `bus_dout` is zero and the byte order field has no effect.
- R9: `eot_det` pulses for one cycle three edges after EOT asserts. It may fall in the same cycle as a capture pulse.
- R10: In mode 11 the port makes no capture pulse, no drive, no pop and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous bus reset of the polarity register |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the polarity register, 1 the transfer register |
| reg_wdata | input | 8 | Register write data |
| dack_pin | input | 1 | DMA acknowledge pin |
| diow_pin | input | 1 | Write strobe pin |
| dior_pin | input | 1 | Read strobe pin |
| eot_pin | input | 1 | End-of-transfer pin |
| dreq_pin | output | 1 | DMA request level |
| dreq_oe | output | 1 | Enable for the DREQ pin driver |
| bus_din | input | DW | Data from the DMA bus |
| bus_dout | output | DW | Data toward the DMA bus |
| bus_doe | output | 1 | Enable for the data bus driver |
| buf_wr_ready | input | 1 | Buffer can accept a word |
| buf_wr_valid | output | 1 | Captured word is valid (one cycle) |
| buf_wr_data | output | DW | Captured word |
| buf_rd_avail | input | 1 | Buffer can supply a word |
| buf_rd_data | input | DW | Word offered by the buffer |
| buf_rd_pop | output | 1 | Outbound word consumed (one cycle) |
| eot_det | output | 1 | End-of-transfer seen (one cycle) |

## Verification
Two events can land in the same cycle. The last capture strobe of a block can coincide with the end-of-transfer pin. A bus reset can coincide with a CPU write to the polarity register. The bench asserts the write strobe and EOT on the same clock edge and expects `buf_wr_valid` and `eot_det` together, with the correct word. It also raises `bus_rst` in the cycle of a polarity write whose DREQ bit is 0. Afterwards, the DREQ pin level must show the active-high reset polarity.

// File: rtl/dmaport_pkg.sv
package dmaport_pkg;

    typedef enum logic [1:0] {
        MODE_WRSTB   = 2'b00,
        MODE_ACKIN   = 2'b01,
        MODE_ACKBOTH = 2'b10,
        MODE_RSVD    = 2'b11
    } strobe_mode_e;

    typedef struct packed {
        logic [1:0] order;
        logic       eot_pol;
        logic       rsvd;
        logic       ack_pol;
        logic       req_pol;
        logic       wr_pol;
        logic       rd_pol;
    } hwcfg_t;

    typedef struct packed {
        logic         dir_out;
        logic         wide;
        strobe_mode_e mode;
    } xfercfg_t;

    localparam hwcfg_t HW_RESET = hwcfg_t'(8'h04);
    localparam logic [1:0] ORDER_SWAP = 2'b01;

    localparam int IDX_ACK = 0;
    localparam int IDX_WR  = 1;
    localparam int IDX_RD  = 2;
    localparam int IDX_EOT = 3;
    localparam int NUM_HS  = 4;

endpackage

// File: rtl/dmaport_sync.sv
module dmaport_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/dmaport_regs.sv
module dmaport_regs
    import dmaport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rst,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [7:0]    reg_wdata,
    output logic [NUM_HS-1:0] in_pol,
    output logic          req_pol,
    output logic [1:0]    order,
    output xfercfg_t      xfer,
    output logic          cfg_seen
);
    typedef struct packed {
        hwcfg_t   hw;
        xfercfg_t xfer;
        logic     seen;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (reg_wr) begin
            if (reg_sel) begin
                d.xfer = xfercfg_t'(reg_wdata[3:0]);
                d.seen = 1'b1;
            end else begin
                d.hw      = hwcfg_t'(reg_wdata);
                d.hw.rsvd = 1'b0;
            end
        end
        if (bus_rst) begin
            d.hw = HW_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{hw: HW_RESET, xfer: '0, seen: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign in_pol   = {q.hw.eot_pol, q.hw.rd_pol, q.hw.wr_pol, q.hw.ack_pol};
    assign req_pol  = q.hw.req_pol;
    assign order    = q.hw.order;
    assign xfer     = q.xfer;
    assign cfg_seen = q.seen;

    p_bus_rst_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (q.hw == HW_RESET));

    p_rsvd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !bus_rst) |=> !q.hw.rsvd);

    p_seen_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.seen |=> q.seen);

endmodule

// File: rtl/dmaport_lane.sv
module dmaport_lane
    import dmaport_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          wide,
    input  logic [1:0]    order,
    input  logic [DW-1:0] bus_word,
    input  logic [DW-1:0] buf_word,
    output logic [DW-1:0] to_buf,
    output logic [DW-1:0] to_bus
);
    localparam int BW = DW / 2;

    logic swap;
    assign swap = wide && (order == ORDER_SWAP);

    function automatic logic [DW-1:0] arrange(input logic [DW-1:0] w,
                                              input logic is_wide,
                                              input logic do_swap);
        if (!is_wide) begin
            return {{BW{1'b0}}, w[BW-1:0]};
        end else if (do_swap) begin
            return {w[BW-1:0], w[DW-1:BW]};
        end
        return w;
    endfunction

    assign to_buf = arrange(bus_word, wide, swap);
    assign to_bus = arrange(buf_word, wide, swap);

endmodule

// File: rtl/dmaport_top.sv
module dmaport_top
    import dmaport_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rst,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [7:0]    reg_wdata,
    input  logic          dack_pin,
    input  logic          diow_pin,
    input  logic          dior_pin,
    input  logic          eot_pin,
    output logic          dreq_pin,
    output logic          dreq_oe,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic          buf_wr_ready,
    output logic          buf_wr_valid,
    output logic [DW-1:0] buf_wr_data,
    input  logic          buf_rd_avail,
    input  logic [DW-1:0] buf_rd_data,
    output logic          buf_rd_pop,
    output logic          eot_det
);
    typedef struct packed {
        logic [NUM_HS-1:0] act_prev;
        logic              wr_valid;
        logic [DW-1:0]     wr_data;
        logic              doe;
        logic [DW-1:0]     dout;
        logic              pop;
        logic              eot;
        logic              dreq;
        logic              dreq_oe;
    } port_t;

    port_t d, q;

    logic [NUM_HS-1:0] in_pol;
    logic              req_pol;
    logic [1:0]        order;
    xfercfg_t          xfer;
    logic              cfg_seen;
    logic [NUM_HS-1:0] pins_sync;
    logic [NUM_HS-1:0] act;
    logic [DW-1:0]     in_word;
    logic [DW-1:0]     out_word;

    dmaport_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rst  (bus_rst),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .in_pol   (in_pol),
        .req_pol  (req_pol),
        .order    (order),
        .xfer     (xfer),
        .cfg_seen (cfg_seen)
    );

    dmaport_sync #(.W(NUM_HS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({eot_pin, dior_pin, diow_pin, dack_pin}),
        .sync_o (pins_sync)
    );

    dmaport_lane #(.DW(DW)) u_lane (
        .wide    (xfer.wide),
        .order   (order),
        .bus_word(bus_din),
        .buf_word(buf_rd_data),
        .to_buf  (in_word),
        .to_bus  (out_word)
    );

    // Normalise every handshake input to active-high.
    assign act = pins_sync ~^ in_pol;

    function automatic logic pick_cap(input strobe_mode_e m, input logic [NUM_HS-1:0] v);
        case (m)
            MODE_WRSTB:              return v[IDX_WR];
            MODE_ACKIN, MODE_ACKBOTH: return v[IDX_ACK];
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic pick_drv(input strobe_mode_e m, input logic [NUM_HS-1:0] v);
        case (m)
            MODE_WRSTB, MODE_ACKIN: return v[IDX_RD];
            MODE_ACKBOTH:           return v[IDX_ACK];
            default:                return 1'b0;
        endcase
    endfunction

    logic usable;
    logic cap_rise;
    logic drv_now;
    logic drv_was;

    always_comb begin
        usable   = cfg_seen && (xfer.mode != MODE_RSVD);
        cap_rise = pick_cap(xfer.mode, act) && !pick_cap(xfer.mode, q.act_prev);
        drv_now  = pick_drv(xfer.mode, act);
        drv_was  = pick_drv(xfer.mode, q.act_prev);

        d          = q;
        d.act_prev = act;
        d.wr_valid = usable && !xfer.dir_out && cap_rise;
        if (usable && !xfer.dir_out && cap_rise) begin
            d.wr_data = in_word;
        end
        d.doe     = usable && xfer.dir_out && drv_now;
        d.dout    = out_word;
        d.pop     = usable && xfer.dir_out && !drv_now && drv_was;
        d.eot     = cfg_seen && act[IDX_EOT] && !q.act_prev[IDX_EOT];
        d.dreq    = usable && (xfer.dir_out ? buf_rd_avail : buf_wr_ready);
        d.dreq_oe = cfg_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign buf_wr_valid = q.wr_valid;
    assign buf_wr_data  = q.wr_data;
    assign bus_doe      = q.doe;
    assign bus_dout     = q.dout;
    assign buf_rd_pop   = q.pop;
    assign eot_det      = q.eot;
    assign dreq_oe      = q.dreq_oe;
    assign dreq_pin     = q.dreq ~^ req_pol;

    p_oe_needs_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_oe |-> cfg_seen);

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_valid |=> !buf_wr_valid);

    p_doe_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> xfer.dir_out);

    p_pop_after_doe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_pop |-> ($past(bus_doe) && !bus_doe));

    p_eot_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eot_det |=> !eot_det);

    p_mode_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer.mode == MODE_RSVD) |-> (!buf_wr_valid && !bus_doe && !buf_rd_pop));

endmodule

// File: tb/dmaport_top_tb_top.sv
module dmaport_top_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rst = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic          dack_pin = 1'b1;
    logic          diow_pin = 1'b1;
    logic          dior_pin = 1'b1;
    logic          eot_pin = 1'b1;
    logic          dreq_pin;
    logic          dreq_oe;
    logic [DW-1:0] bus_din = '0;
    logic [DW-1:0] bus_dout;
    logic          bus_doe;
    logic          buf_wr_ready = 1'b0;
    logic          buf_wr_valid;
    logic [DW-1:0] buf_wr_data;
    logic          buf_rd_avail = 1'b0;
    logic [DW-1:0] buf_rd_data = '0;
    logic          buf_rd_pop;
    logic          eot_det;

    int checks = 0;
    int errors = 0;
    logic [7:0] hw_b  = 8'h04;
    logic [3:0] cfg_b = 4'h0;

    always #5 clk = ~clk;

    dmaport_top #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .dack_pin(dack_pin), .diow_pin(diow_pin), .dior_pin(dior_pin), .eot_pin(eot_pin),
        .dreq_pin(dreq_pin), .dreq_oe(dreq_oe),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .buf_wr_ready(buf_wr_ready), .buf_wr_valid(buf_wr_valid), .buf_wr_data(buf_wr_data),
        .buf_rd_avail(buf_rd_avail), .buf_rd_data(buf_rd_data), .buf_rd_pop(buf_rd_pop),
        .eot_det(eot_det)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] actual, input logic [31:0] expect_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expect_v);
        end
    endtask

    // Pin level for a logical state given a polarity bit (0 = active low).
    function automatic logic lvl(input logic active, input logic pol);
        return active ~^ pol;
    endfunction

    function automatic logic [DW-1:0] exp_word(input logic [DW-1:0] w,
                                               input logic [7:0] hw, input logic [3:0] cfg);
        if (!cfg[2]) return {8'h00, w[7:0]};
        if (hw[7:6] == 2'b01) return {w[7:0], w[15:8]};
        return w;
    endfunction

    // which: 0 = DACK, 1 = write strobe, 2 = read strobe, 3 = EOT
    task automatic strobe(input int which, input logic active);
        case (which)
            0: dack_pin = lvl(active, hw_b[3]);
            1: diow_pin = lvl(active, hw_b[1]);
            2: dior_pin = lvl(active, hw_b[0]);
            default: eot_pin = lvl(active, hw_b[5]);
        endcase
    endtask

    task automatic set_idle();
        for (int k = 0; k < 4; k++) strobe(k, 1'b0);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel) cfg_b = data[3:0];
        else     hw_b  = data & 8'hEF;
        set_idle();
        repeat (6) @(negedge clk);
    endtask

    function automatic int cap_strobe(input logic [1:0] m);
        return (m == 2'b00) ? 1 : 0;
    endfunction

    function automatic int drv_strobe(input logic [1:0] m);
        return (m == 2'b10) ? 0 : 2;
    endfunction

    task automatic do_in(input int which, input logic [DW-1:0] din, input bit expect_hit,
                         input string req);
        @(negedge clk);
        bus_din = din;
        strobe(which, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk(buf_wr_valid == expect_hit, req, "buf_wr_valid", buf_wr_valid, expect_hit);
        if (expect_hit)
            chk(buf_wr_data == exp_word(din, hw_b, cfg_b), req, "buf_wr_data",
                buf_wr_data, exp_word(din, hw_b, cfg_b));
        @(posedge clk);
        #1;
        chk(buf_wr_valid == 1'b0, "R5", "pulse width", buf_wr_valid, 0);
        @(negedge clk);
        strobe(which, 1'b0);
        repeat (5) @(negedge clk);
    endtask

    task automatic do_out(input int which, input logic [DW-1:0] w, input bit expect_hit,
                          input string req);
        @(negedge clk);
        buf_rd_data = w;
        strobe(which, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk(bus_doe == expect_hit, req, "bus_doe on", bus_doe, expect_hit);
        if (expect_hit)
            chk(bus_dout == exp_word(w, hw_b, cfg_b), req, "bus_dout",
                bus_dout, exp_word(w, hw_b, cfg_b));
        @(negedge clk);
        strobe(which, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk(buf_rd_pop == expect_hit, "R6", "buf_rd_pop", buf_rd_pop, expect_hit);
        chk(bus_doe == 1'b0, "R6", "bus_doe off", bus_doe, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_dreq(input logic rdy, input logic avail, input string req);
        logic want;
        @(negedge clk);
        buf_wr_ready = rdy; buf_rd_avail = avail;
        repeat (2) @(posedge clk);
        #1;
        want = (cfg_b[1:0] != 2'b11) && (cfg_b[3] ? avail : rdy);
        chk(dreq_pin == lvl(want, hw_b[2]), req, "dreq_pin", dreq_pin, lvl(want, hw_b[2]));
    endtask

    task automatic do_eot(input string req);
        @(negedge clk);
        strobe(3, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk(eot_det == 1'b1, req, "eot_det", eot_det, 1);
        @(posedge clk);
        #1;
        chk(eot_det == 1'b0, req, "eot_det width", eot_det, 0);
        @(negedge clk);
        strobe(3, 1'b0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        set_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 R2: reset state
        chk(dreq_oe == 1'b0, "R2", "dreq_oe after reset", dreq_oe, 0);
        chk(buf_wr_valid == 1'b0 && bus_doe == 1'b0 && eot_det == 1'b0, "R1", "idle outputs",
            {buf_wr_valid, bus_doe, eot_det}, 0);
        wr_reg(1'b0, 8'h04);
        chk(dreq_oe == 1'b0, "R2", "dreq_oe after polarity write only", dreq_oe, 0);

        // R2 R1 R3: first transfer write, inbound 16-bit, mode 00, reset polarities
        @(negedge clk);
        buf_wr_ready = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; cfg_b = 4'h4;
        chk(dreq_oe == 1'b0, "R2", "dreq_oe one edge after", dreq_oe, 0);
        @(negedge clk);
        chk(dreq_oe == 1'b1, "R2", "dreq_oe two edges after", dreq_oe, 1);
        chk(dreq_pin == 1'b1, "R1", "dreq active high at reset", dreq_pin, 1);
        do_in(1, 16'hA5C3, 1'b1, "R1 R5");

        // R9 with R5: capture strobe and EOT in the same cycle
        @(negedge clk);
        bus_din = 16'h1234;
        strobe(1, 1'b1); strobe(3, 1'b1);
        repeat (3) @(posedge clk);
        #1;
        chk(buf_wr_valid == 1'b1, "R5", "capture with eot", buf_wr_valid, 1);
        chk(eot_det == 1'b1, "R9", "eot with capture", eot_det, 1);
        chk(buf_wr_data == 16'h1234, "R5", "word with eot", buf_wr_data, 16'h1234);
        @(negedge clk);
        set_idle();
        repeat (5) @(negedge clk);

        // R1: bus reset beats a same-cycle polarity write
        wr_reg(1'b0, 8'h00);
        chk_dreq(1'b1, 1'b0, "R3");
        chk(dreq_pin == 1'b0, "R3", "dreq active low", dreq_pin, 0);
        @(negedge clk);
        bus_rst = 1'b1; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'hFB;
        @(negedge clk);
        bus_rst = 1'b0; reg_wr = 1'b0; hw_b = 8'h04;
        set_idle();
        repeat (6) @(negedge clk);
        chk(dreq_pin == 1'b1, "R1", "bus reset polarity", dreq_pin, 1);

        // R8: 8-bit bus ignores byte order
        wr_reg(1'b0, 8'h44);
        wr_reg(1'b1, 8'h00);
        do_in(1, 16'hABCD, 1'b1, "R8");
        wr_reg(1'b1, 8'h08);
        do_out(2, 16'h9E71, 1'b1, "R8");

        // R7: swap on 16-bit
        wr_reg(1'b1, 8'h04);
        do_in(1, 16'hBEEF, 1'b1, "R7");

        // R10: reserved mode
        wr_reg(1'b1, 8'h07);
        chk_dreq(1'b1, 1'b1, "R10");
        do_in(0, 16'h5555, 1'b0, "R10");
        do_in(1, 16'h5555, 1'b0, "R10");
        wr_reg(1'b1, 8'h0F);
        do_out(0, 16'h7777, 1'b0, "R10");
        do_out(2, 16'h7777, 1'b0, "R10");

        // Random configurations
        for (int it = 0; it < 40; it++) begin
            logic [1:0] m;
            logic [7:0] hw;
            logic [3:0] cf;
            m  = 2'($urandom % 3);
            hw = 8'($urandom) & 8'hEF;
            cf = {1'($urandom), 1'($urandom), m};
            wr_reg(1'b0, hw);
            wr_reg(1'b1, {4'h0, cf});
            if (!cf[3]) begin
                do_in(cap_strobe(m), 16'($urandom), 1'b1, "R5 R4 R7");
                do_in((m == 2'b00) ? 0 : 1, 16'($urandom), 1'b0, "R5");
            end else begin
                do_out(drv_strobe(m), 16'($urandom), 1'b1, "R6 R4 R7");
                do_out((m == 2'b10) ? 2 : 0, 16'($urandom), 1'b0, "R6");
            end
            chk_dreq(1'($urandom), 1'($urandom), "R3");
            do_eot("R9 R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule